// File: doc/BRIEF.md
# Link Mode Priority Resolver

This block settles the operating mode of an Ethernet twisted-pair link once auto-negotiation has finished. It receives two 16-bit words: the local advertisement and the ability word the link partner sent. It intersects the technology abilities of the two words and keeps the best mode that both ends can run. Resolution is gated by the partner's selector field. The block reports speed, duplex, whether the four-pair 100 Mb/s signalling was chosen, and whether no shared mode exists.

The negotiation engine pulses a completion strobe for one cycle after the partner word becomes valid. The resolver captures its decision on that clock edge. It raises a result-valid pulse in the next cycle and holds the result until the next strobe. A remote-fault indication from the partner is passed on beside the result. The fault does not stop resolution.

Top module: `an_resolver`

## Requirements
- R1: After reset, every result output is 0: res_valid, res_speed100, res_full_duplex, res_t4, res_no_common and res_rfault.
- R2: The ability bits in both words sit at these positions: bit 5 is 10 Mb/s half duplex, bit 6 is 10 Mb/s full duplex, bit 7 is 100 Mb/s TX half duplex, bit 8 is 100 Mb/s TX full duplex, and bit 9 is 100 Mb/s T4. A mode is usable only when both words set its bit.
- R3: If 100 Mb/s TX full duplex is usable, it wins: speed100=1, full_duplex=1, t4=0.
- R4: If TX full duplex is not usable, T4 comes next and beats TX half duplex and both 10 Mb/s modes. T4 gives speed100=1, full_duplex=0, t4=1.
- R5: Below T4 the order is TX half duplex (speed100=1, full_duplex=0), then 10 Mb/s full duplex (speed100=0, full_duplex=1), then 10 Mb/s half duplex (speed100=0, full_duplex=0). T4 is 0 in all three.
- R6: If the two words share no ability bit, res_no_common=1 and speed100, full_duplex and t4 are all 0.
- R7: If the partner selector (bits 4:0 of the partner word) differs from 00001, res_no_common=1 and no mode is reported, even when ability bits are shared.
- R8: A strobe sampled on a rising edge loads the result on that edge, and res_valid is 1 for exactly the following cycle. Without a strobe, all result outputs keep their values whatever the input words do.
- R9: res_rfault takes bit 13 of the partner word at each strobe, and the mode is still resolved normally.
- R10: The following bits have no effect on the mode: bits 15 and 14 of both words, bit 13 of the local word, the local selector, and bits 12:10 of both words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_word | input | 16 | Local advertisement word |
| lp_word | input | 16 | Link partner ability word |
| an_done | input | 1 | One-cycle completion strobe |
| res_valid | output | 1 | One-cycle pulse: new result present |
| res_speed100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| res_full_duplex | output | 1 | 1 = full duplex |
| res_t4 | output | 1 | 100 Mb/s T4 chosen |
| res_no_common | output | 1 | No usable shared mode |
| res_rfault | output | 1 | Partner reports remote fault |

## Verification
The words are applied in several patterns:
- A single shared ability bit checks that each mode is decoded correctly.
- Pairs of shared bits on either side of each priority boundary show the ordering, in particular T4 placed between the two TX modes.
- Words with a full ability field on one side and a single bit on the other show that the intersection is taken, not the union.
- Disjoint words, and shared words with a wrong partner selector, separate the two causes of the no-common flag.
- Changing the words without a strobe, and flipping the ignored bits, show that the result is held and that only the ability and selector fields matter.

// File: rtl/an_res_pkg.sv
package an_res_pkg;

  // number of technology abilities, fixed by the priority order
  localparam int NUM_ABIL = 5;

  // ability index inside the extracted field (field bit 0 = lowest)
  localparam int IDX_10HD = 0;
  localparam int IDX_10FD = 1;
  localparam int IDX_TXHD = 2;
  localparam int IDX_TXFD = 3;
  localparam int IDX_T4   = 4;

  typedef enum logic [2:0] {
    MD_NONE = 3'd0,
    MD_10HD = 3'd1,
    MD_10FD = 3'd2,
    MD_TXHD = 3'd3,
    MD_T4   = 3'd4,
    MD_TXFD = 3'd5
  } an_mode_e;

  typedef struct packed {
    logic speed100;
    logic fdx;
    logic t4;
    logic none;
  } an_attr_t;

  // rank 0 is the highest priority; returns the ability index it tests
  function automatic int rank_to_idx(input int rank);
    case (rank)
      0:       return IDX_TXFD;
      1:       return IDX_T4;
      2:       return IDX_TXHD;
      3:       return IDX_10FD;
      default: return IDX_10HD;
    endcase
  endfunction

  function automatic an_mode_e rank_to_mode(input int rank);
    case (rank)
      0:       return MD_TXFD;
      1:       return MD_T4;
      2:       return MD_TXHD;
      3:       return MD_10FD;
      default: return MD_10HD;
    endcase
  endfunction

  function automatic an_attr_t mode_attr(input an_mode_e m);
    an_attr_t a;
    a = '0;
    case (m)
      MD_TXFD: begin a.speed100 = 1'b1; a.fdx = 1'b1; end
      MD_T4:   begin a.speed100 = 1'b1; a.t4  = 1'b1; end
      MD_TXHD: begin a.speed100 = 1'b1; end
      MD_10FD: begin a.fdx = 1'b1; end
      MD_10HD: begin end
      default: begin a.none = 1'b1; end
    endcase
    return a;
  endfunction

endpackage

// File: rtl/an_ability_extract.sv
module an_ability_extract #(
  parameter int WORD_W   = 16,
  parameter int ABIL_LSB = 5,
  parameter int SEL_W    = 5,
  parameter int SEL_CSMA = 1
) (
  input  logic [WORD_W-1:0]              adv_word,
  input  logic [WORD_W-1:0]              lp_word,
  output logic [an_res_pkg::NUM_ABIL-1:0] common,
  output logic                           sel_ok
);
  localparam int ABIL_MSB = ABIL_LSB + an_res_pkg::NUM_ABIL - 1;

  logic [an_res_pkg::NUM_ABIL-1:0] adv_abil;
  logic [an_res_pkg::NUM_ABIL-1:0] lp_abil;
  logic [SEL_W-1:0]                lp_sel;

  assign adv_abil = adv_word[ABIL_MSB:ABIL_LSB];
  assign lp_abil  = lp_word[ABIL_MSB:ABIL_LSB];
  assign lp_sel   = lp_word[SEL_W-1:0];

  assign common = adv_abil & lp_abil;
  assign sel_ok = (lp_sel == SEL_W'(SEL_CSMA));

  // local selector and control bits take no part in the decision
  logic unused_bits;
  assign unused_bits = ^{adv_word[WORD_W-1:ABIL_MSB+1], adv_word[ABIL_LSB-1:0],
                         lp_word[WORD_W-1:ABIL_MSB+1]};
endmodule

// File: rtl/an_prio_pick.sv
module an_prio_pick
  import an_res_pkg::*;
(
  input  logic [NUM_ABIL-1:0] common,
  input  logic                sel_ok,
  output logic [NUM_ABIL-1:0] grant,
  output an_mode_e            mode
);
  logic [NUM_ABIL-1:0] hit;
  logic [NUM_ABIL:0]   blocked;

  assign blocked[0] = ~sel_ok;

  for (genvar r = 0; r < NUM_ABIL; r++) begin : g_rank
    assign hit[r]       = common[rank_to_idx(r)];
    assign grant[r]     = hit[r] & ~blocked[r];
    assign blocked[r+1] = blocked[r] | hit[r];
  end

  always_comb begin
    mode = MD_NONE;
    for (int r = NUM_ABIL - 1; r >= 0; r--) begin
      if (grant[r]) mode = rank_to_mode(r);
    end
  end
endmodule

// File: rtl/an_result_reg.sv
module an_result_reg
  import an_res_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  an_mode_e mode,
  input  logic     rfault_in,
  output logic     res_valid,
  output an_attr_t attr_q,
  output logic     rfault_q
);
  an_attr_t attr_d;
  assign attr_d = mode_attr(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      attr_q    <= '0;
      rfault_q  <= 1'b0;
    end else begin
      res_valid <= load;
      if (load) begin
        attr_q   <= attr_d;
        rfault_q <= rfault_in;
      end
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({attr_q, rfault_q}));
endmodule

// File: rtl/an_resolver.sv
module an_resolver #(
  parameter int WORD_W   = 16,
  parameter int ABIL_LSB = 5,
  parameter int SEL_W    = 5,
  parameter int SEL_CSMA = 1,
  parameter int RFLT_BIT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] adv_word,
  input  logic [WORD_W-1:0] lp_word,
  input  logic              an_done,
  output logic              res_valid,
  output logic              res_speed100,
  output logic              res_full_duplex,
  output logic              res_t4,
  output logic              res_no_common,
  output logic              res_rfault
);
  import an_res_pkg::*;

  logic [NUM_ABIL-1:0] common;
  logic                sel_ok;
  logic [NUM_ABIL-1:0] grant;
  an_mode_e            mode;
  an_attr_t            attr_q;

  an_ability_extract #(
    .WORD_W(WORD_W), .ABIL_LSB(ABIL_LSB), .SEL_W(SEL_W), .SEL_CSMA(SEL_CSMA)
  ) u_extract (
    .adv_word(adv_word), .lp_word(lp_word), .common(common), .sel_ok(sel_ok)
  );

  an_prio_pick u_pick (
    .common(common), .sel_ok(sel_ok), .grant(grant), .mode(mode)
  );

  an_result_reg u_reg (
    .clk(clk), .rst_n(rst_n), .load(an_done), .mode(mode),
    .rfault_in(lp_word[RFLT_BIT]), .res_valid(res_valid),
    .attr_q(attr_q), .rfault_q(res_rfault)
  );

  assign res_speed100    = attr_q.speed100;
  assign res_full_duplex = attr_q.fdx;
  assign res_t4          = attr_q.t4;
  assign res_no_common   = attr_q.none;

  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r6_none_excl: assert property (@(posedge clk) disable iff (!rst_n)
    res_no_common |-> !(res_speed100 || res_full_duplex || res_t4));
  a_r4_t4_attrs: assert property (@(posedge clk) disable iff (!rst_n)
    res_t4 |-> (res_speed100 && !res_full_duplex));
  a_r7_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (an_done && lp_word[SEL_W-1:0] != SEL_W'(SEL_CSMA)) |=> res_no_common);
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    an_done |=> res_valid);
  a_r8_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !an_done |=> !res_valid);
  a_r9_fault_capture: assert property (@(posedge clk) disable iff (!rst_n)
    an_done |=> (res_rfault == $past(lp_word[RFLT_BIT])));
endmodule

// File: tb/sim_an_resolver.sv
module sim_an_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] adv_word = '0;
  logic [15:0] lp_word = '0;
  logic        an_done = 1'b0;
  logic        res_valid, res_speed100, res_full_duplex, res_t4, res_no_common, res_rfault;

  int vectors = 0;
  int miscompares = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic [4:0] last_exp = '0;
  bit         done_all = 1'b0;

  always #10 clk = ~clk;

  an_resolver u0 (
    .clk(clk), .rst_n(rst_n), .adv_word(adv_word), .lp_word(lp_word),
    .an_done(an_done), .res_valid(res_valid), .res_speed100(res_speed100),
    .res_full_duplex(res_full_duplex), .res_t4(res_t4),
    .res_no_common(res_no_common), .res_rfault(res_rfault)
  );

  // expected result {no_common, rfault, t4, fdx, speed100}
  function automatic logic [4:0] model(input logic [15:0] a, input logic [15:0] p);
    logic [4:0] c;
    logic       f;
    c = a[9:5] & p[9:5];
    f = p[13];
    if (p[4:0] != 5'b00001 || c == 5'b0) return {1'b1, f, 3'b000};
    if (c[3]) return {1'b0, f, 3'b011};
    if (c[4]) return {1'b0, f, 3'b101};
    if (c[2]) return {1'b0, f, 3'b001};
    if (c[1]) return {1'b0, f, 3'b010};
    return {1'b0, f, 3'b000};
  endfunction

  function automatic logic [4:0] outs();
    return {res_no_common, res_rfault, res_t4, res_full_duplex, res_speed100};
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // driver: pushes expectation and pulses the strobe for one cycle
  task automatic apply(input string tag, input logic [15:0] a, input logic [15:0] p);
    @(negedge clk);
    adv_word = a;
    lp_word  = p;
    an_done  = 1'b1;
    exp_q.push_back(model(a, p));
    tag_q.push_back(tag);
    @(negedge clk);
    an_done = 1'b0;
    last_exp = model(a, p);
  endtask

  // monitor: pops and compares when a result appears
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected valid", 5'b1, 5'b0);
        end else begin
          string t;
          logic [4:0] e;
          t = tag_q.pop_front();
          e = exp_q.pop_front();
          check(t, outs(), e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_all) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {outs(), res_valid}, 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {outs(), res_valid}, 6'b0);

    // single shared bits (R2)
    apply("R2 10HD only",  16'h0021, 16'h0021);
    apply("R2 10FD only",  16'h0041, 16'h0041);
    apply("R2 TXHD only",  16'h0081, 16'h0081);
    apply("R2 TXFD only",  16'h0101, 16'h0101);
    apply("R2 T4 only",    16'h0201, 16'h0201);
    // intersection, not union
    apply("R2 intersect",  16'h03E1, 16'h0041);
    apply("R2 intersect2", 16'h0021, 16'h03E1);
    // priority boundaries
    apply("R3 all abil",   16'h03E1, 16'h03E1);
    apply("R3 TXFD>T4",    16'h0301, 16'h0301);
    apply("R4 T4>TXHD",    16'h0281, 16'h0281);
    apply("R4 T4>10FD",    16'h0241, 16'h0241);
    apply("R4 T4 no TXFD", 16'h02E1, 16'h03E1);
    apply("R5 TXHD>10FD",  16'h00C1, 16'h00C1);
    apply("R5 10FD>10HD",  16'h0061, 16'h0061);
    apply("R5 TXHD>10HD",  16'h00A1, 16'h00A1);
    // no common mode
    apply("R6 disjoint",   16'h0141, 16'h02A1);
    apply("R6 empty",      16'h0001, 16'h0001);
    // selector
    apply("R7 sel 00000",  16'h03E1, 16'h03E0);
    apply("R7 sel 00010",  16'h03E1, 16'h03E2);
    apply("R7 sel 11111",  16'h0121, 16'h013F);
    // remote fault
    apply("R9 fault TXFD", 16'h0101, 16'h2101);
    apply("R9 fault none", 16'h0101, 16'h2041);
    // ignored bits
    apply("R10 ctl bits",  16'hFC20, 16'hDC21);
    apply("R10 adv sel",   16'h009F, 16'h0081);

    // hold without strobe (R8)
    @(negedge clk);
    adv_word = 16'h03E1;
    lp_word  = 16'h23E1;
    repeat (3) begin
      @(negedge clk);
      check("R8 hold", {outs(), res_valid}, {last_exp, 1'b0});
    end
    apply("R8 reload", 16'h0101, 16'h0101);
    repeat (2) @(negedge clk);
    check("R8 drained", 5'(exp_q.size()), 5'd0);

    done_all = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule